// File: doc/BRIEF.md
# Address-Driven Key Matrix Scanner

This block scans an 8x8 key matrix the way a small 8-bit processor would: with I/O reads alone, and no row latch. A built-in sequencer plays the processor. It issues reads to one port whose low address byte is fixed. The high address byte of each read is the row-drive pattern. Whatever the matrix returns on its columns during that read becomes the data word. The port decode looks only at the low address byte and the two strobes, so any high byte reaches the matrix.

The sequencer waits out an idle interval and then makes a single probe read with every row driven. If no column is pulled low, it goes back to waiting. If a column is low, it drives the rows one at a time until it finds the first row with a closure. It notes the key and waits out a debounce interval. It then searches again from row 0. A key is reported only when both searches give the same code. Once a key is reported, the probes go on, and the first probe that finds no closure reports the release.

Rows, columns and the bus strobes are all active low. The key code is `{row[2:0], column[2:0]}`, where the row is the lowest active row and the column is the lowest pulled-low column in that row.

Top module: `keyscan_bus`

## Requirements
- R1: While reset is held: `row_n` is 8'hFF, `bus_iorq_n` and `bus_rd_n` are 1, and `key_valid`, `key_up` and `key_code` are 0. The first read comes after IDLE_CYC cycles with no read.
- R2: Rows are driven only during a decoded read, when both strobes are low and `bus_addr[7:0]` equals PORT_LO. During such a read `row_n` equals `bus_addr[15:8]`. At all other times `row_n` is 8'hFF.
- R3: The decode ignores `bus_addr[15:8]`. A read with the all-rows pattern 8'h00 and a read with any single-row pattern both select the port.
- R4: During a decoded read `bus_data` equals `col_n` in the same cycle. At all other times it is 8'hFF.
- R5: Each idle interval has exactly IDLE_CYC cycles with no read. It is followed by one probe read with high byte 8'h00. A probe that returns 8'hFF leads back to the idle interval.
- R6: After a probe that finds a closure, and no key is held, the sequencer reads rows 0, 1, 2, ... on consecutive cycles. Row k uses high byte ~(1<<k). The search stops at the first row that returns a value other than 8'hFF, or after row 7.
- R7: A found key starts a debounce interval of DEB_CYC cycles with no read. After it comes a second search from row 0. `key_valid` is raised only if the second search gives the same code as the first.
- R8: `key_valid` is a one-cycle pulse in the cycle after the confirming row read. `key_code` is then {row index, lowest zero column index} and keeps that value until the next report.
- R9: While a key is held, a probe that finds a closure starts no row search and produces no new report.
- R10: The first probe that returns 8'hFF after a report pulses `key_up` for one cycle. `key_up` never pulses otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_n | input | 8 | Matrix columns, pulled up, low where a closed key meets a driven row |
| row_n | output | 8 | Matrix row drivers, low = driven |
| bus_addr | output | 16 | Address of the current I/O cycle |
| bus_iorq_n | output | 1 | I/O request strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_data | output | 8 | Data word returned by the port |
| key_code | output | 6 | {row, column} of the last reported key |
| key_valid | output | 1 | One-cycle pulse when a debounced key is reported |
| key_up | output | 1 | One-cycle pulse when the held key is released |

## Verification
The checker watches the bus contract on every cycle:
- every per-row read drives exactly one row;
- consecutive row reads step down by one row;
- a probe always follows a cycle with no read;
- the two output pulses last one cycle and come only after a matching read.

Only the bench's scenarios can show the timing and the choice of keys. These include the length of the idle and debounce intervals, which key wins when several are pressed, and a short bounce that must not be reported. They also include the single report per held key and the release that follows.

// File: rtl/keyscan_bus.sv
module keyscan_bus #(
  parameter logic [7:0] PORT_LO  = 8'hFE,
  parameter int         IDLE_CYC = 64,
  parameter int         DEB_CYC  = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  col_n,
  output logic [7:0]  row_n,
  output logic [15:0] bus_addr,
  output logic        bus_iorq_n,
  output logic        bus_rd_n,
  output logic [7:0]  bus_data,
  output logic [5:0]  key_code,
  output logic        key_valid,
  output logic        key_up
);
  localparam int CNT_MAX = (IDLE_CYC > DEB_CYC) ? IDLE_CYC : DEB_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] IDLE_LD = CW'(IDLE_CYC - 1);
  localparam logic [CW-1:0] DEB_LD  = CW'(DEB_CYC - 1);

  typedef enum logic [1:0] {S_WAIT, S_PROBE, S_ROW, S_DEB} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    row;
  logic          conf, held;
  logic [5:0]    cand;
  logic          rd_act, port_sel, hit;
  logic [7:0]    hi_byte;
  logic [2:0]    low_col;
  logic [5:0]    code_now;

  assign rd_act     = (st == S_PROBE) || (st == S_ROW);
  assign hi_byte    = (st == S_PROBE) ? 8'h00 :
                      (st == S_ROW)   ? ~(8'd1 << row) : 8'hFF;
  assign bus_addr   = {hi_byte, PORT_LO};
  assign bus_iorq_n = ~rd_act;
  assign bus_rd_n   = ~rd_act;

  assign port_sel = !bus_iorq_n && !bus_rd_n && (bus_addr[7:0] == PORT_LO);
  assign row_n    = port_sel ? bus_addr[15:8] : 8'hFF;
  assign bus_data = port_sel ? col_n : 8'hFF;
  assign hit      = (bus_data != 8'hFF);

  always_comb begin
    low_col = 3'd0;
    for (int c = 7; c >= 0; c--)
      if (!bus_data[c]) low_col = 3'(c);
  end
  assign code_now = {row, low_col};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_WAIT;
      cnt       <= IDLE_LD;
      row       <= 3'd0;
      conf      <= 1'b0;
      held      <= 1'b0;
      cand      <= 6'd0;
      key_code  <= 6'd0;
      key_valid <= 1'b0;
      key_up    <= 1'b0;
    end else begin
      key_valid <= 1'b0;
      key_up    <= 1'b0;
      case (st)
        S_WAIT: begin
          if (cnt == '0) st <= S_PROBE;
          else cnt <= cnt - 1'b1;
        end
        S_PROBE: begin
          if (hit && !held) begin
            st   <= S_ROW;
            row  <= 3'd0;
            conf <= 1'b0;
          end else begin
            if (!hit && held) begin
              key_up <= 1'b1;
              held   <= 1'b0;
            end
            st  <= S_WAIT;
            cnt <= IDLE_LD;
          end
        end
        S_ROW: begin
          if (hit) begin
            if (!conf) begin
              cand <= code_now;
              st   <= S_DEB;
              cnt  <= DEB_LD;
            end else begin
              if (code_now == cand) begin
                key_valid <= 1'b1;
                key_code  <= code_now;
                held      <= 1'b1;
              end
              st  <= S_WAIT;
              cnt <= IDLE_LD;
            end
          end else if (row == 3'd7) begin
            st  <= S_WAIT;
            cnt <= IDLE_LD;
          end else begin
            row <= row + 1'b1;
          end
        end
        S_DEB: begin
          if (cnt == '0) begin
            st   <= S_ROW;
            row  <= 3'd0;
            conf <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_WAIT;
      endcase
    end
  end
endmodule

module keyscan_bus_chk #(
  parameter logic [7:0] PORT_LO = 8'hFE
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  row_n,
  input logic [15:0] bus_addr,
  input logic        bus_iorq_n,
  input logic        bus_rd_n,
  input logic [7:0]  bus_data,
  input logic [5:0]  key_code,
  input logic        key_valid,
  input logic        key_up
);
  logic probe_rd, row_rd;
  assign probe_rd = !bus_rd_n && !bus_iorq_n && bus_addr[7:0] == PORT_LO && bus_addr[15:8] == 8'h00;
  assign row_rd   = !bus_rd_n && !bus_iorq_n && bus_addr[7:0] == PORT_LO && bus_addr[15:8] != 8'h00;

  a_r2_idle_rows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n |-> (row_n == 8'hFF && bus_data == 8'hFF));

  a_r6_single_row: assert property (@(posedge clk) disable iff (!rst_n)
    row_rd |-> $countones(row_n) == 7);

  a_r6_row_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_rd && $past(row_rd)) |-> (row_n == {$past(row_n[6:0]), 1'b1}));

  a_r5_probe_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    probe_rd |-> $past(bus_rd_n));

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);

  a_r8_valid_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> $past(row_rd && bus_data != 8'hFF));

  a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> $stable(key_code));

  a_r10_up_after_empty_probe: assert property (@(posedge clk) disable iff (!rst_n)
    key_up |-> $past(probe_rd && bus_data == 8'hFF));

  a_r10_up_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    key_up |=> !key_up);
endmodule

bind keyscan_bus keyscan_bus_chk #(.PORT_LO(PORT_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_n(row_n), .bus_addr(bus_addr),
  .bus_iorq_n(bus_iorq_n), .bus_rd_n(bus_rd_n), .bus_data(bus_data),
  .key_code(key_code), .key_valid(key_valid), .key_up(key_up)
);

// File: tb/tb_keyscan_bus.sv
module tb_keyscan_bus;
  localparam logic [7:0] PORT = 8'hFE;
  localparam int IDLE = 4;
  localparam int DEB  = 6;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  col_n;
  logic [7:0]  row_n;
  logic [15:0] bus_addr;
  logic        bus_iorq_n, bus_rd_n;
  logic [7:0]  bus_data;
  logic [5:0]  key_code;
  logic        key_valid, key_up;
  logic [63:0] keys = '0;

  int vectors = 0, miscompares = 0, cycles = 0;
  int n_valid = 0, n_up = 0, last_code = -1;

  always #5 clk = ~clk;

  keyscan_bus #(.PORT_LO(PORT), .IDLE_CYC(IDLE), .DEB_CYC(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .col_n(col_n), .row_n(row_n), .bus_addr(bus_addr),
    .bus_iorq_n(bus_iorq_n), .bus_rd_n(bus_rd_n), .bus_data(bus_data),
    .key_code(key_code), .key_valid(key_valid), .key_up(key_up));

  function automatic logic [7:0] cols_for(logic [63:0] k, logic [7:0] rn);
    logic [7:0] v = 8'hFF;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        if (!rn[r] && k[r*8+c]) v[c] = 1'b0;
    return v;
  endfunction

  always_comb col_n = cols_for(keys, row_n);

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 probe, 2 row search, 3 debounce
  int ph, cnt, rw, cand, ecode;
  bit conf, held, ev, eu;

  function automatic int low_zero(logic [7:0] d);
    for (int c = 0; c < 8; c++) if (!d[c]) return c;
    return 0;
  endfunction

  task automatic model_reset();
    ph = 0; cnt = IDLE - 1; rw = 0; cand = 0; ecode = 0;
    conf = 0; held = 0; ev = 0; eu = 0;
  endtask

  function automatic logic [7:0] model_hi();
    if (ph == 1) return 8'h00;
    if (ph == 2) return ~(8'd1 << rw);
    return 8'hFF;
  endfunction

  task automatic model_step();
    logic [7:0] d;
    ev = 0; eu = 0;
    d = (ph == 1 || ph == 2) ? cols_for(keys, model_hi()) : 8'hFF;
    if (ph == 0) begin
      if (cnt == 0) ph = 1; else cnt--;
    end else if (ph == 1) begin
      if (d != 8'hFF && !held) begin ph = 2; rw = 0; conf = 0; end
      else begin
        if (d == 8'hFF && held) begin eu = 1; held = 0; end
        ph = 0; cnt = IDLE - 1;
      end
    end else if (ph == 2) begin
      if (d != 8'hFF) begin
        int code = rw * 8 + low_zero(d);
        if (!conf) begin cand = code; ph = 3; cnt = DEB - 1; end
        else begin
          if (code == cand) begin ev = 1; ecode = code; held = 1; end
          ph = 0; cnt = IDLE - 1;
        end
      end else if (rw == 7) begin ph = 0; cnt = IDLE - 1; end
      else rw++;
    end else begin
      if (cnt == 0) begin ph = 2; rw = 0; conf = 1; end else cnt--;
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      model_reset();
    end else begin
      logic [7:0] hi;
      bit rd;
      hi = model_hi();
      rd = (ph == 1 || ph == 2);
      chk("R2/R3 row_n", row_n, hi);
      chk("R5/R6 bus_addr", bus_addr, {hi, PORT});
      chk("R2 bus_rd_n", bus_rd_n, !rd);
      chk("R2 bus_iorq_n", bus_iorq_n, !rd);
      chk("R4 bus_data", bus_data, rd ? cols_for(keys, hi) : 8'hFF);
      chk("R7/R8 key_valid", key_valid, ev);
      chk("R8 key_code", key_code, ecode);
      chk("R9/R10 key_up", key_up, eu);
      if (key_valid) begin n_valid++; last_code = key_code; end
      if (key_up) n_up++;
      model_step();
    end
  end

  task automatic hold(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_counts();
    n_valid = 0; n_up = 0; last_code = -1;
  endtask

  task automatic press_only(int r, int c);
    keys = '0; keys[r*8+c] = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 row_n in reset", row_n, 8'hFF);
    chk("R1 rd_n in reset", bus_rd_n, 1);
    chk("R1 valid in reset", key_valid, 0);
    chk("R1 up in reset", key_up, 0);
    chk("R1 code in reset", key_code, 0);
    @(posedge clk); #1 rst_n = 1;

    // R1/R5: idle first, then a probe only
    for (int i = 0; i < IDLE; i++) begin
      @(negedge clk);
      chk("R1 no read during first idle", bus_rd_n, 1);
    end
    @(negedge clk);
    chk("R5 probe drives all rows", row_n, 8'h00);
    hold(30);

    // R7/R8/R9/R10: single key, held long, then released
    clear_counts();
    press_only(3, 5);
    hold(120);
    chk("R9 one report for held key", n_valid, 1);
    chk("R8 code row3 col5", last_code, 6'o35);
    keys = '0;
    hold(20);
    chk("R10 one release", n_up, 1);

    // R7: short bounce never reported
    clear_counts();
    hold(3);
    press_only(1, 2);
    hold(3);
    keys = '0;
    hold(40);
    chk("R7 bounce not reported", n_valid, 0);
    chk("R10 no release without report", n_up, 0);

    // R6/R8: two rows pressed, lowest row wins
    clear_counts();
    keys = '0; keys[5*8+0] = 1; keys[2*8+1] = 1;
    hold(60);
    chk("R6 lowest row reported", last_code, 6'o21);
    keys = '0; hold(20);

    // R8: same row, lowest column wins
    clear_counts();
    keys = '0; keys[4*8+6] = 1; keys[4*8+4] = 1;
    hold(60);
    chk("R8 lowest column reported", last_code, 6'o44);
    keys = '0; hold(20);

    // R8 corners: row 7 col 7 and row 0 col 0
    clear_counts();
    press_only(7, 7); hold(60);
    chk("R8 code 63", last_code, 63);
    keys = '0; hold(20);
    clear_counts();
    press_only(0, 0); hold(60);
    chk("R8 code 0", last_code, 0);
    keys = '0; hold(20);

    // R7: key changes mid-debounce, compared by the model
    clear_counts();
    press_only(6, 1); hold(7);
    press_only(6, 3); hold(80);
    chk("R7 final report is settled key", last_code, 6'o63);
    keys = '0; hold(30);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog expired, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule